// File: doc/BRIEF.md
# Temperature Sample FIFO with Watermark

This block buffers temperature words produced by a sensor conversion engine. Each finished conversion offers one 16-bit word on a sample strobe. The block stores it in a 32-deep circular buffer. A host drains the buffer one byte at a time through a small byte-wide register port. The same port shows the write pointer, the read pointer, the stored word count and a count of samples that were lost. The read pointer can be written. A control register selects the policy for a full buffer: the newest sample either overwrites the oldest word or is dropped.

An almost-full flag tells the host when the buffer nears its limit. The limit is set by a programmable margin below the depth. The flag has two reassert behaviours and two possible clear sources. A self-clearing flush bit empties the buffer in one cycle.

The sample input has no back-pressure. A strobe on `samp_valid` is always taken in the cycle it is seen, and the full-buffer policy decides what happens to it. Register accesses complete in one cycle. Read data is combinational from the address in the cycle `reg_rd` is high. Side effects of a read take place at the following clock edge.

Top module: `temp_fifo`

## Requirements
- R1: The write pointer (address 3) and the read pointer (address 4) are 5-bit values. Each one wraps from 31 to 0.
- R2: The word count (address 6) ranges from 0 to 32. It rises by one on a stored sample and falls by one on a pop. When a sample and a pop arrive in the same cycle, the count does not change.
- R3: The lost counter (address 5) rises by one for each sample that arrives while the count is 32, and it stops at 31. A pop clears it to zero. A loss in the same cycle as the pop then counts as one.
- R4: When CTRL (address 1) bit 0 is 0, a sample that arrives while the buffer is full is dropped. The pointers, the count and the stored words stay as they were.
- R5: When CTRL bit 0 is 1, a sample that arrives while the buffer is full replaces the oldest word. Both pointers then advance by one and the count stays at 32.
- R6: Reads of address 7 alternate between two bytes of the word at the read pointer. The high byte comes first. The read that returns the low byte pops the word. A read of address 7 on an empty buffer returns 0x00, does not pop and does not change the byte order.
- R7: The almost-full condition holds when the count is at least 32 minus WMARK[4:0] (address 2). The flag appears on STAT (address 0) bit 0 and on the `almost_full` pin.
- R8: When CTRL bit 1 is 0, a read of STAT clears the flag. Any later sample that leaves the count in the condition sets the flag again.
- R9: When CTRL bit 1 is 1, only a sample that takes the count from below the limit into the condition sets the flag.
- R10: When CTRL bit 2 is 1, a read of address 7 also clears the flag. When CTRL bit 2 is 0, only a STAT read clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: Writing CTRL with bit 3 set zeroes both pointers, the count, the lost counter, the byte order and the flag. Bit 3 always reads back as 0.
- R12: A write to address 4 loads the read pointer and restarts the byte order at the high byte. It leaves the count unchanged.
- R13: After reset, every register and the flag read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | One-cycle strobe: a conversion result is offered |
| samp_data | input | 16 | Signed temperature word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current address |
| almost_full | output | 1 | Almost-full flag |

## Verification
The bench first runs directed sequences. Filling past 32 words under each full-buffer policy shows the difference between dropping a sample and overwriting the oldest word, and the pointers and lost count show which one happened. Watermark runs with the flag cleared while the count stays at the limit show the difference between level reassert and entry-only reassert. Runs where a sample and a pop fall in the same cycle check the count rule. A long random mix of samples, byte reads, status reads, policy changes, flushes and read-pointer writes follows. Every read byte and the flag pin are compared with a bench model.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_STAT  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_WMARK = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_WPTR  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_RPTR  = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_LOST  = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_COUNT = 3'd6;
  localparam logic [REG_AW-1:0] ADDR_DATA  = 3'd7;

  localparam int CTRL_ROLL  = 0;
  localparam int CTRL_ENTRY = 1;
  localparam int CTRL_DCLR  = 2;
  localparam int CTRL_FLUSH = 3;

  typedef struct packed {
    logic data_clears;
    logic entry_only;
    logic rollover;
  } ctrl_t;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 16,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsf_ptrctl.sv
module tsf_ptrctl #(
  parameter int DEPTH  = 32,
  parameter int PTR_W  = 5,
  parameter int CNT_W  = 6,
  parameter int LOST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              flush,
  input  logic              data_rd,
  input  logic              rptr_wr,
  input  logic [PTR_W-1:0]  rptr_wdata,
  input  logic              rollover,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt,
  output logic [LOST_W-1:0] lost,
  output logic              phase,
  output logic              mem_we,
  output logic              pop,
  output logic              lose,
  output logic              full
);
  localparam logic [CNT_W-1:0]  FULL_C   = CNT_W'(DEPTH);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  logic              empty;
  logic              grow;
  logic [LOST_W-1:0] lost_base;
  logic [LOST_W-1:0] lost_nxt;
  logic [PTR_W-1:0]  rptr_nxt;

  assign full   = (count == FULL_C);
  assign empty  = (count == '0);
  // the low byte read completes a word
  assign pop    = data_rd && phase && !empty && !flush;
  assign lose   = push && full && !flush;
  assign grow   = push && !full && !flush;
  assign mem_we = push && !flush && (!full || rollover);

  always_comb begin
    count_nxt = count;
    if (grow && !pop)      count_nxt = count + CNT_W'(1);
    else if (pop && !grow) count_nxt = count - CNT_W'(1);
  end

  always_comb begin
    lost_base = pop ? '0 : lost;
    lost_nxt  = (lose && lost_base != LOST_MAX) ? lost_base + LOST_W'(1) : lost_base;
  end

  assign rptr_nxt = rptr + PTR_W'(pop) + PTR_W'(lose && rollover);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      lost  <= '0;
      phase <= 1'b0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      lost  <= '0;
      phase <= 1'b0;
    end else begin
      wptr  <= wptr + PTR_W'(mem_we);
      rptr  <= rptr_wr ? rptr_wdata : rptr_nxt;
      count <= count_nxt;
      lost  <= lost_nxt;
      if (rptr_wr)                phase <= 1'b0;
      else if (data_rd && !empty) phase <= ~phase;
    end
  end
endmodule

// File: rtl/tsf_wmark.sv
module tsf_wmark #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             flush,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [PTR_W-1:0] wmark,
  input  logic             entry_only,
  input  logic             data_clears,
  input  logic             stat_rd,
  input  logic             data_rd,
  output logic             af
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] limit;
  logic             in_now;
  logic             in_next;
  logic             set_ev;
  logic             clr_ev;

  assign limit   = DEPTH_C - CNT_W'(wmark);
  assign in_now  = (count >= limit);
  assign in_next = (count_nxt >= limit);

  always_comb begin
    if (entry_only) set_ev = push && !flush && in_next && !in_now;
    else            set_ev = push && !flush && in_next;
  end

  assign clr_ev = stat_rd || (data_clears && data_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      af <= 1'b0;
    else if (flush)  af <= 1'b0;
    else if (set_ev) af <= 1'b1;
    else if (clr_ev) af <= 1'b0;
  end
endmodule

// File: rtl/tsf_regfile.sv
module tsf_regfile
  import tsf_pkg::*;
#(
  parameter int PTR_W  = 5,
  parameter int CNT_W  = 6,
  parameter int LOST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [CNT_W-1:0]  count,
  input  logic [LOST_W-1:0] lost,
  input  logic              af,
  input  logic [BYTE_W-1:0] data_byte,
  output ctrl_t             cfg,
  output logic [PTR_W-1:0]  wmark,
  output logic              flush,
  output logic              rptr_wr,
  output logic [PTR_W-1:0]  rptr_wdata,
  output logic              stat_rd,
  output logic              data_rd,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic ctrl_wr;
  logic wmark_wr;

  assign ctrl_wr    = reg_wr && (reg_addr == ADDR_CTRL);
  assign wmark_wr   = reg_wr && (reg_addr == ADDR_WMARK);
  assign flush      = ctrl_wr && reg_wdata[CTRL_FLUSH];
  assign rptr_wr    = reg_wr && (reg_addr == ADDR_RPTR);
  assign rptr_wdata = reg_wdata[PTR_W-1:0];
  assign stat_rd    = reg_rd && (reg_addr == ADDR_STAT);
  assign data_rd    = reg_rd && (reg_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      wmark <= '0;
    end else begin
      if (ctrl_wr) begin
        cfg.rollover    <= reg_wdata[CTRL_ROLL];
        cfg.entry_only  <= reg_wdata[CTRL_ENTRY];
        cfg.data_clears <= reg_wdata[CTRL_DCLR];
      end
      if (wmark_wr) wmark <= reg_wdata[PTR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STAT:  reg_rdata = BYTE_W'(af);
      ADDR_CTRL:  reg_rdata = BYTE_W'({cfg.data_clears, cfg.entry_only, cfg.rollover});
      ADDR_WMARK: reg_rdata = BYTE_W'(wmark);
      ADDR_WPTR:  reg_rdata = BYTE_W'(wptr);
      ADDR_RPTR:  reg_rdata = BYTE_W'(rptr);
      ADDR_LOST:  reg_rdata = BYTE_W'(lost);
      ADDR_COUNT: reg_rdata = BYTE_W'(count);
      default:    reg_rdata = data_byte;
    endcase
  end
endmodule

// File: rtl/temp_fifo.sv
module temp_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LOST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [WORD_W-1:0] samp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              almost_full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  ctrl_t             cfg;
  logic [PTR_W-1:0]  wmark;
  logic              flush;
  logic              rptr_wr;
  logic [PTR_W-1:0]  rptr_wdata;
  logic              stat_rd;
  logic              data_rd;
  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  rptr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  count_nxt;
  logic [LOST_W-1:0] lost;
  logic              phase;
  logic              mem_we;
  logic              pop;
  logic              lose;
  logic              full;
  logic [WORD_W-1:0] head_word;
  logic [BYTE_W-1:0] data_byte;

  tsf_regfile #(.PTR_W(PTR_W), .CNT_W(CNT_W), .LOST_W(LOST_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .wptr       (wptr),
    .rptr       (rptr),
    .count      (count),
    .lost       (lost),
    .af         (almost_full),
    .data_byte  (data_byte),
    .cfg        (cfg),
    .wmark      (wmark),
    .flush      (flush),
    .rptr_wr    (rptr_wr),
    .rptr_wdata (rptr_wdata),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .reg_rdata  (reg_rdata)
  );

  tsf_ptrctl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .LOST_W(LOST_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (samp_valid),
    .flush      (flush),
    .data_rd    (data_rd),
    .rptr_wr    (rptr_wr),
    .rptr_wdata (rptr_wdata),
    .rollover   (cfg.rollover),
    .wptr       (wptr),
    .rptr       (rptr),
    .count      (count),
    .count_nxt  (count_nxt),
    .lost       (lost),
    .phase      (phase),
    .mem_we     (mem_we),
    .pop        (pop),
    .lose       (lose),
    .full       (full)
  );

  tsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (wptr),
    .wdata (samp_data),
    .raddr (rptr),
    .rdata (head_word)
  );

  tsf_wmark #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_wmark (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (samp_valid),
    .flush       (flush),
    .count       (count),
    .count_nxt   (count_nxt),
    .wmark       (wmark),
    .entry_only  (cfg.entry_only),
    .data_clears (cfg.data_clears),
    .stat_rd     (stat_rd),
    .data_rd     (data_rd),
    .af          (almost_full)
  );

  always_comb begin
    if (count == '0) data_byte = '0;
    else if (phase)  data_byte = head_word[BYTE_W-1:0];
    else             data_byte = head_word[WORD_W-1:BYTE_W];
  end
endmodule

// File: rtl/temp_fifo_chk.sv
module temp_fifo_chk #(
  parameter int DEPTH  = 32,
  parameter int PTR_W  = 5,
  parameter int CNT_W  = 6,
  parameter int LOST_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              samp_valid,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic              almost_full,
  input logic              flush,
  input logic              pop,
  input logic              lose,
  input logic              full,
  input logic              rollover,
  input logic              rptr_wr,
  input logic [PTR_W-1:0]  wptr,
  input logic [PTR_W-1:0]  rptr,
  input logic [CNT_W-1:0]  count,
  input logic [LOST_W-1:0] lost
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && wptr == '0 && rptr == '0 && lost == '0 && !almost_full));

  assert_lost_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !lose && !flush) |=> (lost == '0));

  assert_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && full && !rollover && !pop && !flush && !rptr_wr)
      |=> ($stable(wptr) && $stable(rptr) && $stable(count)));

  assert_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && full && rollover && !pop && !flush && !rptr_wr)
      |=> (wptr == PTR_W'($past(wptr) + 1'b1) && rptr == PTR_W'($past(rptr) + 1'b1)
           && count == CNT_W'(DEPTH)));

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && !samp_valid && !flush) |=> !almost_full);
endmodule

bind temp_fifo temp_fifo_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .LOST_W(LOST_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .samp_valid  (samp_valid),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .almost_full (almost_full),
  .flush       (flush),
  .pop         (pop),
  .lose        (lose),
  .full        (full),
  .rollover    (cfg.rollover),
  .rptr_wr     (rptr_wr),
  .wptr        (wptr),
  .rptr        (rptr),
  .count       (count),
  .lost        (lost)
);

// File: tb/temp_fifo_bench.sv
module temp_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [15:0] samp_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        almost_full;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  temp_fifo u_temp_fifo (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .almost_full(almost_full)
  );

  // bench model of the requirements
  logic [15:0] m_mem [32];
  logic [4:0]  m_w, m_r, m_lost, m_wm;
  logic [5:0]  m_cnt;
  bit          m_roll, m_type, m_dclr, m_af, m_ph;

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R11";
      3'd2: return "R7";
      3'd3: return "R1";
      3'd4: return "R12";
      3'd5: return "R3";
      3'd6: return "R2";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input logic [2:0] a);
    case (a)
      3'd0: return {7'b0, m_af};
      3'd1: return {5'b0, m_dclr, m_type, m_roll};
      3'd2: return {3'b0, m_wm};
      3'd3: return {3'b0, m_w};
      3'd4: return {3'b0, m_r};
      3'd5: return {3'b0, m_lost};
      3'd6: return {2'b0, m_cnt};
      default: begin
        if (m_cnt == 0) return 8'h00;
        return m_ph ? m_mem[m_r][7:0] : m_mem[m_r][15:8];
      end
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_w = 0; m_r = 0; m_lost = 0; m_wm = 0; m_cnt = 0;
    m_roll = 0; m_type = 0; m_dclr = 0; m_af = 0; m_ph = 0;
  endtask

  task automatic m_update(input bit pv, input logic [15:0] pd, input bit rd,
                          input bit wr, input logic [2:0] a, input logic [7:0] wd);
    bit full, empty, data_rd, stat_rd, pop, lose, wrote, setv, clrv, in_now, in_nx;
    logic [5:0] nc, thr;
    logic [4:0] base;
    if (wr && a == 3'd1 && wd[3]) begin
      m_w = 0; m_r = 0; m_cnt = 0; m_lost = 0; m_ph = 0; m_af = 0;
      m_roll = wd[0]; m_type = wd[1]; m_dclr = wd[2];
      return;
    end
    full = (m_cnt == 32); empty = (m_cnt == 0);
    data_rd = rd && a == 3'd7; stat_rd = rd && a == 3'd0;
    pop = data_rd && m_ph && !empty;
    lose = pv && full;
    wrote = pv && (!full || m_roll);
    if (wrote) m_mem[m_w] = pd;
    nc = m_cnt + 6'((pv && !full) ? 1 : 0) - 6'(pop ? 1 : 0);
    thr = 6'd32 - {1'b0, m_wm};
    in_now = m_cnt >= thr; in_nx = nc >= thr;
    setv = pv && (m_type ? (in_nx && !in_now) : in_nx);
    clrv = stat_rd || (m_dclr && data_rd);
    if (setv) m_af = 1; else if (clrv) m_af = 0;
    base = pop ? 5'd0 : m_lost;
    if (lose && base != 5'd31) base = base + 1;
    m_lost = base;
    m_w = m_w + 5'(wrote);
    m_r = m_r + 5'(pop) + 5'(lose && m_roll);
    if (wr && a == 3'd4) begin m_r = wd[4:0]; m_ph = 0; end
    else if (data_rd && !empty) m_ph = ~m_ph;
    if (wr && a == 3'd1) begin m_roll = wd[0]; m_type = wd[1]; m_dclr = wd[2]; end
    if (wr && a == 3'd2) m_wm = wd[4:0];
    m_cnt = nc;
  endtask

  task automatic step(input bit pv, input logic [15:0] pd, input bit rd, input bit wr,
                      input logic [2:0] a, input logic [7:0] wd, output logic [7:0] got);
    logic [7:0] e;
    @(negedge clk);
    samp_valid = pv; samp_data = pd; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd;
    e = exp_byte(a);
    #1;
    got = reg_rdata;
    if (rd) chk(tag_of(a), got, e);
    m_update(pv, pd, rd, wr, a, wd);
    @(posedge clk);
    #1;
    samp_valid = 0; reg_rd = 0; reg_wr = 0;
    chk("R7 pin", almost_full, m_af);
  endtask

  task automatic push(input logic [15:0] d);
    logic [7:0] g;
    step(1, d, 0, 0, 3'd0, 8'd0, g);
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] g);
    step(0, 16'd0, 1, 0, a, 8'd0, g);
  endtask

  task automatic wrreg(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] g;
    step(0, 16'd0, 0, 1, a, d, g);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13: reset state
    for (int a = 0; a < 7; a++) begin
      rdreg(3'(a), g);
      chk("R13", g, 0);
    end
    chk("R13 pin", almost_full, 0);

    // R6: byte order
    push(16'h1CE8); push(16'hFF38);
    rdreg(3'd7, g); chk("R6 msb", g, 8'h1C);
    rdreg(3'd7, g); chk("R6 lsb", g, 8'hE8);
    rdreg(3'd7, g); chk("R6 msb", g, 8'hFF);
    rdreg(3'd7, g); chk("R6 lsb", g, 8'h38);
    rdreg(3'd7, g); chk("R6 empty", g, 8'h00);
    rdreg(3'd6, g); chk("R6 count", g, 0);

    // R4: discard policy
    wrreg(3'd1, 8'h08);
    for (int i = 0; i < 35; i++) push(16'h0100 + 16'(i));
    rdreg(3'd6, g); chk("R4 count", g, 32);
    rdreg(3'd3, g); chk("R4 wptr", g, 0);
    rdreg(3'd4, g); chk("R4 rptr", g, 0);
    rdreg(3'd5, g); chk("R3 lost", g, 3);
    rdreg(3'd7, g); chk("R4 msb", g, 8'h01);
    rdreg(3'd7, g); chk("R4 lsb", g, 8'h00);
    rdreg(3'd5, g); chk("R3 pop clears", g, 0);

    // R5: overwrite policy
    wrreg(3'd1, 8'h08);
    rdreg(3'd6, g); chk("R11 count", g, 0);
    rdreg(3'd1, g); chk("R11 bit", g, 0);
    wrreg(3'd1, 8'h01);
    for (int i = 0; i < 34; i++) push(16'h0200 + 16'(i));
    rdreg(3'd3, g); chk("R5 wptr", g, 2);
    rdreg(3'd4, g); chk("R5 rptr", g, 2);
    rdreg(3'd6, g); chk("R5 count", g, 32);
    rdreg(3'd5, g); chk("R3 lost", g, 2);
    rdreg(3'd7, g); chk("R5 msb", g, 8'h02);
    rdreg(3'd7, g); chk("R5 lsb", g, 8'h02);

    // R3: saturation
    wrreg(3'd1, 8'h08);
    for (int i = 0; i < 72; i++) push(16'(i));
    rdreg(3'd5, g); chk("R3 sat", g, 31);

    // R9: entry-only reassert
    wrreg(3'd1, 8'h0A); wrreg(3'd2, 8'd2);
    for (int i = 0; i < 29; i++) push(16'(i));
    chk("R9 below", almost_full, 0);
    push(16'h0030);
    chk("R9 entry", almost_full, 1);
    rdreg(3'd0, g); chk("R9 stat", g, 1);
    chk("R9 cleared", almost_full, 0);
    push(16'h0031);
    chk("R9 no reassert", almost_full, 0);
    for (int i = 0; i < 4; i++) rdreg(3'd7, g);
    push(16'h0032);
    chk("R9 re-entry", almost_full, 1);

    // R8: level reassert
    wrreg(3'd1, 8'h08); wrreg(3'd1, 8'h00);
    for (int i = 0; i < 30; i++) push(16'(i));
    chk("R8 set", almost_full, 1);
    rdreg(3'd0, g);
    chk("R8 cleared", almost_full, 0);
    push(16'h0040);
    chk("R8 reassert", almost_full, 1);

    // R10: data read clear source
    wrreg(3'd1, 8'h0C); wrreg(3'd2, 8'd31);
    push(16'hABCD);
    chk("R10 set", almost_full, 1);
    rdreg(3'd7, g);
    chk("R10 data clears", almost_full, 0);
    wrreg(3'd1, 8'h00);
    push(16'h1234);
    chk("R10 set", almost_full, 1);
    rdreg(3'd7, g);
    chk("R10 data no clear", almost_full, 1);

    // R2: push and pop together
    wrreg(3'd1, 8'h08);
    push(16'h1111); push(16'h2222);
    rdreg(3'd7, g);
    step(1, 16'h3333, 1, 0, 3'd7, 8'd0, g);
    chk("R2 lsb", g, 8'h11);
    rdreg(3'd6, g); chk("R2 same cycle", g, 2);

    // R12: read pointer write
    wrreg(3'd4, 8'd5);
    rdreg(3'd4, g); chk("R12 rptr", g, 5);
    rdreg(3'd6, g); chk("R12 count", g, 2);

    // R1: wrap
    wrreg(3'd1, 8'h08);
    for (int i = 0; i < 35; i++) begin
      push(16'(i));
      rdreg(3'd7, g); rdreg(3'd7, g);
    end
    rdreg(3'd3, g); chk("R1 wptr wrap", g, 3);
    rdreg(3'd4, g); chk("R1 rptr wrap", g, 3);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) push(16'($urandom));
      else if (r < 60) rdreg(3'd7, g);
      else if (r < 66) step(1, 16'($urandom), 1, 0, 3'd7, 8'd0, g);
      else if (r < 74) rdreg(3'd0, g);
      else if (r < 86) rdreg(3'($urandom_range(1, 6)), g);
      else if (r < 92) wrreg(3'd1, {4'b0, 4'($urandom_range(0, 7))} | (($urandom_range(0, 9) == 0) ? 8'h08 : 8'h00));
      else if (r < 97) wrreg(3'd2, 8'($urandom_range(0, 31)));
      else wrreg(3'd4, 8'($urandom_range(0, 31)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule